// File: doc/BRIEF.md
# Byte-Port Interrupt Request Controller

This block gathers interrupt requests from up to eight peripheral sources into one pending-request register and drives a single level output toward a system-level interrupt collector. Sources set request bits with a bit-vector post strobe and remove them with a bit-vector clear strobe. Software reaches the block through a small byte-wide register port with four locations:

| Address | Read | Write |
|---|---|---|
| 0 (primary command) | pending requests | end-of-interrupt |
| 1 (primary mask) | mask | mask |
| 2 (secondary command) | always zero | ignored |
| 3 (secondary mask) | stored byte | stored byte |

The primary mask is held internally as an enable vector, which is the complement of the byte software writes. The output is not a plain AND of requests and enables. It is event driven:
- a post always raises it;
- an end-of-interrupt always drops it;
- a primary mask write re-evaluates it against the enabled requests;
- a clear can only lower it.

The secondary mask is stored for software only and never takes part in delivery. Read data comes back registered, one clock after the read strobe. A separate wide-read qualifier selects the full-width return that firmware uses when it can only issue 64-bit loads.

Top module: `pic_lite`

## Requirements
- R1: After a synchronous reset:
  - the request register is zero;
  - all enables are zero, so a primary mask read returns 0xFF;
  - the secondary mask is zero;
  - `irq_out` is low;
  - `rd_data` is zero.
- R2: A write to address 1 stores the bitwise complement of `wr_data` as the enable vector. A later byte read of address 1 returns the written byte in `rd_data[7:0]`, with the upper bits zero, one clock after the read strobe.
- R3: A write to address 1 re-evaluates the output. One clock later `irq_out` equals the OR-reduction of (requests AND new enables): it rises if that term is nonzero and falls if it is zero.
- R4: A nonzero `src_post` ORs its bits into the request register and sets `irq_out` high one clock later, even when every posted bit is masked.
- R5: A nonzero `src_clear` removes its bits from the request register. `irq_out` then falls only if no enabled request remains, and a clear never raises `irq_out`.
- R6: A write to address 0 clears request bit number `wr_data[3:0]` and drives `irq_out` low one clock later, whatever requests remain.
- R7: An end-of-interrupt whose index `wr_data[3:0]` is 8 or more leaves the request register unchanged, but still drives `irq_out` low.
- R8: A byte read of address 0 returns the request register in `rd_data[7:0]`.
- R9: A wide read (`rd_wide`=1) of address 0 returns the request register zero-extended to 64 bits. A wide read of any other address returns zero.
- R10: A byte read of address 2 always returns 0x00, and a write to address 2 changes nothing.
- R11: A write to address 3 stores the byte uncomplemented, reads back unchanged, and never changes `irq_out`.
- R12: Same-cycle precedence for `irq_out` is: end-of-interrupt, then post, then primary mask write, then clear. The request register takes the post first, then the clear, then the end-of-interrupt bit. Reads return the state from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| rd_wide | input | 1 | Read qualifier: 1 selects a 64-bit read |
| addr | input | 2 | Register address (0 to 3) |
| wr_data | input | 8 | Write byte |
| rd_data | output | 64 | Registered read data, updated one clock after `rd_en` |
| src_post | input | 8 | Request set vector from sources |
| src_clear | input | 8 | Request clear vector from sources |
| irq_out | output | 1 | Registered aggregated interrupt level |

## Verification
The hardest states to reach are those where the output disagrees with the plain AND of requests and enables. Two examples:
- the output stays high after a post of a masked-only bit;
- a clear leaves the output low while enabled requests exist, after an end-of-interrupt.

The stimulus builds these states deliberately: it posts into a masked line, issues an end-of-interrupt with an out-of-range index, and then applies clears and mask writes. It also lines up an end-of-interrupt, a post, a mask write and a clear in the same cycle to exercise the precedence order. A pseudo-random phase then mixes all strobes so that the model comparison covers their interleavings.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam logic [1:0] PORT_PCMD  = 2'd0;
  localparam logic [1:0] PORT_PMASK = 2'd1;
  localparam logic [1:0] PORT_SCMD  = 2'd2;
  localparam logic [1:0] PORT_SMASK = 2'd3;
  localparam int EOI_IDX_W = 4;

  typedef struct packed {
    logic eoi;
    logic pmask_wr;
    logic smask_wr;
  } wr_decode_t;
endpackage

// File: rtl/pic_req_reg.sv
module pic_req_reg #(
  parameter int REQ_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REQ_W-1:0] post_vec,
  input  logic [REQ_W-1:0] clear_vec,
  input  logic             eoi,
  input  logic [IDX_W-1:0] eoi_idx,
  output logic [REQ_W-1:0] req_next,
  output logic [REQ_W-1:0] req_q
);
  logic [REQ_W-1:0] eoi_vec;

  // One-hot EOI clear; indices at or above REQ_W select no bit.
  for (genvar i = 0; i < REQ_W; i++) begin : g_eoi
    assign eoi_vec[i] = eoi && (eoi_idx == IDX_W'(i));
  end

  always_comb begin
    req_next = ((req_q | post_vec) & ~clear_vec) & ~eoi_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req_next;
  end
endmodule

// File: rtl/pic_mask_bank.sv
module pic_mask_bank #(
  parameter int REQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pmask_wr,
  input  logic             smask_wr,
  input  logic [REQ_W-1:0] wr_byte,
  output logic [REQ_W-1:0] en_next,
  output logic [REQ_W-1:0] en_q,
  output logic [REQ_W-1:0] smask_q
);
  always_comb begin
    en_next = pmask_wr ? ~wr_byte : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      smask_q <= '0;
    end else begin
      en_q <= en_next;
      if (smask_wr) smask_q <= wr_byte;
    end
  end
endmodule

// File: rtl/pic_irq_eval.sv
module pic_irq_eval (
  input  logic clk,
  input  logic rst,
  input  logic eoi,
  input  logic post_any,
  input  logic pmask_wr,
  input  logic clear_any,
  input  logic live_next,
  output logic irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = irq_q;
    if (eoi)            irq_d = 1'b0;
    else if (post_any)  irq_d = 1'b1;
    else if (pmask_wr)  irq_d = live_next;
    else if (clear_any) irq_d = irq_q & live_next;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_d;
  end
endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux #(
  parameter int REQ_W  = 8,
  parameter int WIDE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_wide,
  input  logic [1:0]        sel,
  input  logic [REQ_W-1:0]  req_q,
  input  logic [REQ_W-1:0]  en_q,
  input  logic [REQ_W-1:0]  smask_q,
  output logic [WIDE_W-1:0] rd_q
);
  import pic_pkg::*;
  logic [REQ_W-1:0]  byte_val;
  logic [WIDE_W-1:0] word_val;

  always_comb begin
    unique case (sel)
      PORT_PCMD:  byte_val = req_q;
      PORT_PMASK: byte_val = ~en_q;
      PORT_SCMD:  byte_val = '0;
      default:    byte_val = smask_q;
    endcase
    if (rd_wide) word_val = (sel == PORT_PCMD) ? WIDE_W'(req_q) : '0;
    else         word_val = WIDE_W'(byte_val);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= word_val;
  end
endmodule

// File: rtl/pic_lite.sv
module pic_lite #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int WIDE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              rd_wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [WIDE_W-1:0] rd_data,
  input  logic [DATA_W-1:0] src_post,
  input  logic [DATA_W-1:0] src_clear,
  output logic              irq_out
);
  import pic_pkg::*;
  localparam int REQ_W = DATA_W;

  wr_decode_t       dec;
  logic [1:0]       sel;
  logic [REQ_W-1:0] req_next, req_q, en_next, en_q, smask_q;
  logic             live_next;

  assign sel = addr[1:0];

  always_comb begin
    dec.eoi      = wr_en && (sel == PORT_PCMD);
    dec.pmask_wr = wr_en && (sel == PORT_PMASK);
    dec.smask_wr = wr_en && (sel == PORT_SMASK);
  end

  pic_req_reg #(.REQ_W(REQ_W), .IDX_W(EOI_IDX_W)) u_req (
    .clk(clk), .rst(rst), .post_vec(src_post), .clear_vec(src_clear),
    .eoi(dec.eoi), .eoi_idx(wr_data[EOI_IDX_W-1:0]),
    .req_next(req_next), .req_q(req_q)
  );

  pic_mask_bank #(.REQ_W(REQ_W)) u_mask (
    .clk(clk), .rst(rst), .pmask_wr(dec.pmask_wr), .smask_wr(dec.smask_wr),
    .wr_byte(wr_data), .en_next(en_next), .en_q(en_q), .smask_q(smask_q)
  );

  assign live_next = |(req_next & en_next);

  pic_irq_eval u_irq (
    .clk(clk), .rst(rst), .eoi(dec.eoi), .post_any(|src_post),
    .pmask_wr(dec.pmask_wr), .clear_any(|src_clear),
    .live_next(live_next), .irq_q(irq_out)
  );

  pic_read_mux #(.REQ_W(REQ_W), .WIDE_W(WIDE_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_wide(rd_wide), .sel(sel),
    .req_q(req_q), .en_q(en_q), .smask_q(smask_q), .rd_q(rd_data)
  );
endmodule

// File: rtl/pic_lite_chk.sv
module pic_lite_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] src_post,
  input logic [DATA_W-1:0] src_clear,
  input logic              irq_out,
  input logic [DATA_W-1:0] req_q,
  input logic [DATA_W-1:0] en_q
);
  logic eoi_w, pm_w, sm_w, any_post;
  assign eoi_w    = wr_en && (addr[1:0] == 2'd0);
  assign pm_w     = wr_en && (addr[1:0] == 2'd1);
  assign sm_w     = wr_en && (addr[1:0] == 2'd3);
  assign any_post = |src_post;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_out && req_q == '0 && en_q == '0)); // R1
  AST_MASK_REEVAL: assert property (@(posedge clk) disable iff (rst)
    (pm_w && !any_post) |=> (irq_out == |(req_q & en_q))); // R3
  AST_POST_RAISES: assert property (@(posedge clk) disable iff (rst)
    (any_post && !eoi_w) |=> irq_out); // R4
  AST_CLEAR_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (!irq_out && !any_post && !pm_w) |=> !irq_out); // R5
  AST_EOI_DROPS: assert property (@(posedge clk) disable iff (rst)
    eoi_w |=> !irq_out); // R6
  AST_SMASK_INERT: assert property (@(posedge clk) disable iff (rst)
    (sm_w && !any_post && src_clear == '0) |=> $stable(irq_out)); // R11
endmodule

bind pic_lite pic_lite_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .src_post(src_post),
  .src_clear(src_clear), .irq_out(irq_out), .req_q(req_q), .en_q(en_q)
);

// File: tb/pic_lite_test.sv
module pic_lite_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, rd_en = 0, rd_wide = 0;
  logic [1:0]  addr = '0;
  logic [7:0]  wr_data = '0, src_post = '0, src_clear = '0;
  logic [63:0] rd_data;
  logic        irq_out;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  int m_req = 0, m_en = 0, m_smask = 0;
  bit m_irq = 0;
  longint unsigned m_rd = 0;

  always #2 clk = ~clk;

  pic_lite uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_wide(rd_wide),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .src_post(src_post), .src_clear(src_clear), .irq_out(irq_out)
  );

  task automatic model_step();
    int nreq, nen, idx;
    bit live;
    bit eoi = wr_en && addr == 0;
    bit pm  = wr_en && addr == 1;
    if (rst) begin
      m_req = 0; m_en = 0; m_smask = 0; m_irq = 0; m_rd = 0;
      return;
    end
    if (rd_en) begin
      if (rd_wide) m_rd = (addr == 0) ? longint'(m_req) : 0;
      else case (addr)
        2'd0: m_rd = m_req;
        2'd1: m_rd = (~m_en) & 8'hFF;
        2'd2: m_rd = 0;
        default: m_rd = m_smask;
      endcase
    end
    nreq = (m_req | int'(src_post)) & ~int'(src_clear) & 8'hFF;
    idx = int'(wr_data[3:0]);
    if (eoi && idx < 8) nreq = nreq & ~(1 << idx);
    nen = pm ? (~int'(wr_data)) & 8'hFF : m_en;
    live = (nreq & nen) != 0;
    if (eoi)                m_irq = 0;
    else if (src_post != 0) m_irq = 1;
    else if (pm)            m_irq = live;
    else if (src_clear != 0) m_irq = m_irq && live;
    if (wr_en && addr == 3) m_smask = int'(wr_data);
    m_req = nreq; m_en = nen;
  endtask

  task automatic compare();
    checks++;
    if (irq_out !== m_irq || rd_data !== m_rd) begin
      fails++;
      $display("FAIL %s: irq=%0b rd=%h expected irq=%0b rd=%h",
               tag, irq_out, rd_data, m_irq, m_rd);
    end
  endtask

  task automatic cyc(input bit w, input bit r, input bit wd, input logic [1:0] a,
                     input logic [7:0] d, input logic [7:0] p, input logic [7:0] c);
    wr_en = w; rd_en = r; rd_wide = wd; addr = a; wr_data = d;
    src_post = p; src_clear = c;
    @(posedge clk);
    model_step();
    #1;
    compare();
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d); cyc(1, 0, 0, a, d, 0, 0); endtask
  task automatic rd(input logic [1:0] a, input bit wd); cyc(0, 1, wd, a, 0, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int lfsr = 32'h1ACE5;
    #1;
    tag = "R1"; rst = 1; idle(); idle(); rst = 0;
    idle(); rd(1, 0); idle(); rd(0, 0); rd(3, 0);
    tag = "R2"; wr(1, 8'hF0); rd(1, 0); idle();
    tag = "R4"; cyc(0, 0, 0, 0, 0, 8'h10, 0); idle();
    tag = "R8"; rd(0, 0);
    tag = "R6"; wr(0, 8'h04); rd(0, 0);
    tag = "R5"; cyc(0, 0, 0, 0, 0, 8'h21, 0); cyc(0, 0, 0, 0, 0, 0, 8'h20); idle();
    cyc(0, 0, 0, 0, 0, 0, 8'h01); idle();
    cyc(0, 0, 0, 0, 0, 8'h03, 0); wr(0, 8'h07); cyc(0, 0, 0, 0, 0, 0, 8'h02); idle();
    wr(0, 8'h00);
    tag = "R3"; cyc(0, 0, 0, 0, 0, 8'h80, 0); wr(1, 8'hF0); idle(); wr(1, 8'h7F); idle();
    tag = "R7"; wr(0, 8'h09); rd(0, 0); wr(0, 8'h0F); rd(0, 0);
    tag = "R9"; rd(0, 1); rd(1, 1); rd(3, 1); rd(2, 1);
    tag = "R10"; rd(2, 0); wr(2, 8'hFF); rd(0, 0); rd(2, 0);
    tag = "R11"; wr(3, 8'h5A); idle(); rd(3, 0); wr(1, 8'h00); idle(); wr(3, 8'h00); idle();
    tag = "R12";
    cyc(1, 0, 0, 0, 8'h01, 8'h03, 0); rd(0, 0);
    cyc(1, 0, 0, 1, 8'hFF, 8'h04, 0); idle();
    cyc(1, 0, 0, 1, 8'h00, 0, 8'h06); idle();
    cyc(1, 1, 0, 0, 8'h01, 0, 8'h01); rd(0, 0);
    cyc(0, 1, 0, 0, 0, 8'h40, 8'h40); rd(0, 0);
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >>> 17); lfsr = lfsr ^ (lfsr << 5);
      cyc(lfsr[0] & lfsr[1], lfsr[2], lfsr[3], lfsr[5:4], lfsr[13:6],
          lfsr[7] ? (lfsr[21:14] & lfsr[29:22]) : 8'h00,
          lfsr[8] ? (lfsr[29:22] & ~lfsr[21:14]) : 8'h00);
    end
    tag = "R1"; rst = 1; idle(); rst = 0; idle(); rd(1, 0); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule